// File: doc/BRIEF.md
# Register-Pair Saturating Long Shifter

This unit joins two 32-bit register values into one 64-bit operand and shifts it by a signed amount held in the low byte of a third register value. It offers six operations. Two are plain shifts that never round or saturate: a logical left shift and an arithmetic right shift. The other four are rounding shifts that saturate. Each comes in an unsigned left-going form and a signed right-going form, and each can saturate at the full 64-bit range or at a 48-bit range carried inside the 64-bit datapath.

The caller presents the low word, the high word, the count word and an operation code together with a one-cycle valid strobe. One clock later the unit returns the shifted pair, split into low and high words the same way, with a matching valid pulse. Any saturation sets a sticky flag. The flag stays set until a clear input is raised.

Top module: `long_shift_unit`

## Requirements
- R1: The operand is {hiWord, loWord}, with loWord in bits 31:0. The result is registered and appears on {outHi, outLo} one clock after inValid, split the same way, with outValid high for that one cycle. When inValid is low, outLo and outHi hold their values.
- R2: The signed count is countWord[7:0], sign-extended, and bits 31:8 are ignored. For codes 0, 2 and 4 a positive count shifts left and a negative count shifts right. Codes 1, 3 and 5 negate the count first, so a positive count shifts right.
- R3: Code 0 (plain left) shifts left with zero fill, or shifts right logically. A magnitude of 64 or more in either direction gives 0. This code never changes satFlag.
- R4: Code 1 (plain arithmetic) shifts right arithmetically, and a right magnitude of 64 or more gives all sign bits. A left shift zero-fills, and a left magnitude of 64 or more gives 0. Overflow is ignored, and satFlag is never changed.
- R5: Codes 2 to 5 round right shifts half-up. The value is shifted by n-1, and the result is that value shifted by one more place plus the last bit shifted out.
- R6: Code 2 (unsigned, 64-bit). A right magnitude of 65 or more gives 0. A left shift that loses a set bit gives all ones and saturates. A left magnitude of 64 or more gives 0 for a zero operand; any other operand saturates.
- R7: Code 3 (signed, 64-bit). An effective right magnitude of 64 or more gives 0. A left shift whose arithmetic shift back does not restore the operand saturates, giving 0x7FFF_FFFF_FFFF_FFFF for a non-negative operand and 0x8000_0000_0000_0000 for a negative one.
- R8: Code 4 (unsigned, 48-bit). A right magnitude of 49 or more gives 0. Any left or right result whose bits 63:48 are not zero saturates to 0x0000_FFFF_FFFF_FFFF. A left magnitude of 48 or more saturates any nonzero operand.
- R9: Code 5 (signed, 48-bit). A left shift below 48 sign-extends the shifted value from bit 47, and it saturates when that differs from the 64-bit shifted value. The saturation value is 0x0000_7FFF_FFFF_FFFF for a non-negative operand and 0xFFFF_8000_0000_0000 for a negative one. An effective right magnitude of 48 or more gives 0, and a shorter right shift keeps the full 64-bit rounded result.
- R10: satFlag is set by any saturation on a valid cycle and stays set until satClear. A saturation in the same cycle as satClear leaves the flag set.
- R11: Codes 6 and 7 copy the operand unchanged and do not touch satFlag.
- R12: After reset, outLo, outHi, outValid and satFlag are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Operand, count and code are valid this cycle |
| op | input | 3 | Operation code (0 to 7, see requirements) |
| loWord | input | 32 | Low half of the operand |
| hiWord | input | 32 | High half of the operand |
| countWord | input | 32 | Count register; only bits 7:0 are used |
| satClear | input | 1 | Clears the sticky saturation flag |
| outValid | output | 1 | Result is valid this cycle |
| outLo | output | 32 | Low half of the result |
| outHi | output | 32 | High half of the result |
| satFlag | output | 1 | Sticky saturation flag |

## Verification
The only state in the block is the result register and the sticky flag. A wrong decode of direction, rounding or saturation width therefore shows up as a wrong output word on the cycle after the valid strobe, and there is nowhere for it to hide for longer. A fault in the flag logic shows up as a satFlag that is set after a plain or pass-through operation, one that drops without a clear, or one that stays up after a clear. The directed cases sit on the thresholds where behaviour changes: magnitudes of 48, 49, 64, 65 and 128, half-way rounding points, and operands one bit inside or outside the saturation range.

// File: rtl/lshift_pkg.sv
package lshift_pkg;

  typedef enum logic [2:0] {
    OP_SHL     = 3'd0,
    OP_SAR     = 3'd1,
    OP_USATL   = 3'd2,
    OP_SSATR   = 3'd3,
    OP_USATL48 = 3'd4,
    OP_SSATR48 = 3'd5,
    OP_KEEP6   = 3'd6,
    OP_KEEP7   = 3'd7
  } shOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic negate;      // flip count sign before use
    logic signedMode;  // arithmetic shifts and signed limits
    logic round;       // round-half-up on right shifts
    logic saturate;    // clamp and report out-of-range results
    logic narrow;      // 48-bit limit instead of 64-bit
    logic bypass;      // copy operand unchanged
  } shStrb_t;

endpackage

// File: rtl/lshift_ctrl.sv
module lshift_ctrl
  import lshift_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [2:0] op,
  input  logic       satHit,
  input  logic       satClear,
  output shStrb_t    strb,
  output logic       satFlag
);

  always_comb begin
    strb = '0;
    case (shOp_e'(op))
      OP_SHL:     strb = '0;
      OP_SAR:     begin strb.negate = 1'b1; strb.signedMode = 1'b1; end
      OP_USATL:   begin strb.round = 1'b1; strb.saturate = 1'b1; end
      OP_SSATR:   begin strb.negate = 1'b1; strb.signedMode = 1'b1;
                        strb.round = 1'b1; strb.saturate = 1'b1; end
      OP_USATL48: begin strb.round = 1'b1; strb.saturate = 1'b1;
                        strb.narrow = 1'b1; end
      OP_SSATR48: begin strb.negate = 1'b1; strb.signedMode = 1'b1;
                        strb.round = 1'b1; strb.saturate = 1'b1;
                        strb.narrow = 1'b1; end
      default:    strb.bypass = 1'b1;
    endcase
  end

  // sticky flag: a new saturation wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  satFlag <= 1'b0;
    else if (inValid && satHit) satFlag <= 1'b1;
    else if (satClear)          satFlag <= 1'b0;
  end

endmodule

// File: rtl/lshift_dp.sv
module lshift_dp
  import lshift_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 8,
  parameter int NARROW_W = 48
) (
  input  shStrb_t               strb,
  input  logic [WORD_W-1:0]     loWord,
  input  logic [WORD_W-1:0]     hiWord,
  input  logic [CNT_W-1:0]      cntByte,
  output logic [2*WORD_W-1:0]   result,
  output logic                  satHit
);

  localparam int FULL_W = 2 * WORD_W;
  localparam int SH_W   = CNT_W + 1;
  localparam int AMT_W  = $clog2(FULL_W);
  localparam int HEAD_W = FULL_W - NARROW_W;

  logic [FULL_W-1:0]        src;
  logic signed [FULL_W-1:0] srcS;
  logic signed [SH_W-1:0]   cntS, effS;
  logic                     isRight;
  logic [SH_W-1:0]          mag, limit;
  logic [AMT_W-1:0]         amt, amtM1;
  logic [FULL_W-1:0]        satVal;

  logic signed [FULL_W-1:0] arShift, arPre;
  logic [FULL_W-1:0]        lgShift, lgPre;
  logic [FULL_W-1:0]        shR, preR, rndR, valR;
  logic [FULL_W-1:0]        valL, backL, extL;
  logic signed [FULL_W-1:0] valLS, backLS;
  logic [FULL_W-1:0]        rightRes, leftRes;
  logic                     rightHit, leftHit;

  assign src  = {hiWord, loWord};
  assign srcS = src;

  // signed count, optional negation, magnitude and direction
  always_comb begin
    cntS    = {{(SH_W-CNT_W){cntByte[CNT_W-1]}}, cntByte};
    effS    = strb.negate ? -cntS : cntS;
    isRight = effS[SH_W-1];
    mag     = isRight ? SH_W'(-effS) : SH_W'(effS);
    limit   = strb.narrow ? SH_W'(NARROW_W) : SH_W'(FULL_W);
    amt     = mag[AMT_W-1:0];
    amtM1   = amt - AMT_W'(1);
  end

  // clamp values for the four saturating flavours
  always_comb begin
    if (strb.narrow) begin
      if (strb.signedMode)
        satVal = src[FULL_W-1]
               ? {{(HEAD_W+1){1'b1}}, {(NARROW_W-1){1'b0}}}
               : {{(HEAD_W+1){1'b0}}, {(NARROW_W-1){1'b1}}};
      else
        satVal = {{HEAD_W{1'b0}}, {NARROW_W{1'b1}}};
    end else begin
      if (strb.signedMode)
        satVal = {src[FULL_W-1], {(FULL_W-1){~src[FULL_W-1]}}};
      else
        satVal = '1;
    end
  end

  // right-going path
  always_comb begin
    arShift = srcS >>> amt;
    arPre   = srcS >>> amtM1;
    lgShift = src >> amt;
    lgPre   = src >> amtM1;
    shR     = strb.signedMode ? arShift : lgShift;
    preR    = strb.signedMode ? arPre : lgPre;
    rndR    = {(strb.signedMode & preR[FULL_W-1]), preR[FULL_W-1:1]}
            + FULL_W'(preR[0]);
    valR    = strb.round ? rndR : shR;
    rightHit = 1'b0;
    if (strb.signedMode) begin
      if (mag >= limit)
        rightRes = strb.round ? '0 : {FULL_W{src[FULL_W-1]}};
      else
        rightRes = valR;
    end else begin
      if (mag >= limit + SH_W'(strb.round)) begin
        rightRes = '0;
      end else if (strb.narrow && strb.saturate &&
                   (valR[FULL_W-1:NARROW_W] != '0)) begin
        rightRes = satVal;
        rightHit = 1'b1;
      end else begin
        rightRes = valR;
      end
    end
  end

  // left-going path
  always_comb begin
    valL   = src << amt;
    valLS  = valL;
    backLS = valLS >>> amt;
    backL  = strb.signedMode ? backLS : (valL >> amt);
    extL   = {{HEAD_W{strb.signedMode & valL[NARROW_W-1]}},
              valL[NARROW_W-1:0]};
    leftHit = 1'b0;
    leftRes = valL;
    if (mag >= limit) begin
      if (strb.saturate && (src != '0)) begin
        leftRes = satVal;
        leftHit = 1'b1;
      end else begin
        leftRes = '0;
      end
    end else if (strb.narrow) begin
      if (strb.saturate && (valL != extL)) begin
        leftRes = satVal;
        leftHit = 1'b1;
      end else begin
        leftRes = extL;
      end
    end else if (strb.saturate && (backL != src)) begin
      leftRes = satVal;
      leftHit = 1'b1;
    end
  end

  always_comb begin
    if (strb.bypass) begin
      result = src;
      satHit = 1'b0;
    end else if (isRight) begin
      result = rightRes;
      satHit = rightHit;
    end else begin
      result = leftRes;
      satHit = leftHit;
    end
  end

endmodule

// File: rtl/long_shift_unit.sv
module long_shift_unit
  import lshift_pkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CNT_W    = 8,
  parameter int NARROW_W = 48
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] loWord,
  input  logic [WORD_W-1:0] hiWord,
  input  logic [WORD_W-1:0] countWord,
  input  logic              satClear,
  output logic              outValid,
  output logic [WORD_W-1:0] outLo,
  output logic [WORD_W-1:0] outHi,
  output logic              satFlag
);

  localparam int FULL_W = 2 * WORD_W;

  shStrb_t           strb;
  logic              satHit;
  logic [FULL_W-1:0] result;
  logic              unusedCountBits;

  assign unusedCountBits = ^countWord[WORD_W-1:CNT_W];

  lshift_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .op       (op),
    .satHit   (satHit),
    .satClear (satClear),
    .strb     (strb),
    .satFlag  (satFlag)
  );

  lshift_dp #(
    .WORD_W   (WORD_W),
    .CNT_W    (CNT_W),
    .NARROW_W (NARROW_W)
  ) u_dp (
    .strb    (strb),
    .loWord  (loWord),
    .hiWord  (hiWord),
    .cntByte (countWord[CNT_W-1:0]),
    .result  (result),
    .satHit  (satHit)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outLo    <= '0;
      outHi    <= '0;
    end else begin
      outValid <= inValid;
      if (inValid) begin
        outLo <= result[WORD_W-1:0];
        outHi <= result[FULL_W-1:WORD_W];
      end
    end
  end

endmodule

// File: rtl/lshift_chk.sv
module lshift_chk #(
  parameter int WORD_W   = 32,
  parameter int NARROW_W = 48
) (
  input logic              clk,
  input logic              rstN,
  input logic              inValid,
  input logic [2:0]        op,
  input logic [WORD_W-1:0] loWord,
  input logic [WORD_W-1:0] hiWord,
  input logic              satClear,
  input logic              outValid,
  input logic [WORD_W-1:0] outLo,
  input logic [WORD_W-1:0] outHi,
  input logic              satFlag
);

  // R1
  valid_pipe_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);

  // R1
  result_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> ($stable(outLo) && $stable(outHi)));

  // R3
  plain_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (op <= 3'd1) && !satClear) |=> $stable(satFlag));

  // R10
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satFlag && !satClear) |=> satFlag);

  // R10
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (satClear && !inValid) |=> !satFlag);

  // R8
  narrow_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (op == 3'd4)) |=> (outHi[WORD_W-1:NARROW_W-WORD_W] == '0));

  // R11
  keep_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && (op[2:1] == 2'b11)) |=>
      ({outHi, outLo} == $past({hiWord, loWord})));

endmodule

bind long_shift_unit lshift_chk #(
  .WORD_W   (WORD_W),
  .NARROW_W (NARROW_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .op       (op),
  .loWord   (loWord),
  .hiWord   (hiWord),
  .satClear (satClear),
  .outValid (outValid),
  .outLo    (outLo),
  .outHi    (outHi),
  .satFlag  (satFlag)
);

// File: tb/sim_long_shift_unit.sv
`timescale 1ns/1ps
module sim_long_shift_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [2:0]  op = '0;
  logic [31:0] loWord = '0, hiWord = '0, countWord = '0;
  logic        satClear = 1'b0;
  logic        outValid;
  logic [31:0] outLo, outHi;
  logic        satFlag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  always #5 clk = ~clk;

  long_shift_unit u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .op(op),
    .loWord(loWord), .hiWord(hiWord), .countWord(countWord),
    .satClear(satClear), .outValid(outValid), .outLo(outLo),
    .outHi(outHi), .satFlag(satFlag)
  );

  task automatic check64(input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic clearFlag();
    @(negedge clk); satClear = 1'b1;
    @(negedge clk); satClear = 1'b0;
  endtask

  task automatic run(input logic [2:0] o, input logic [63:0] src,
                     input logic [31:0] cnt, input logic [63:0] exp,
                     input logic expFlag, input string tag);
    @(negedge clk);
    op = o; {hiWord, loWord} = src; countWord = cnt; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    check64(tag, {outHi, outLo}, exp);
    checkBit({tag, " flag"}, satFlag, expFlag);
  endtask

  task automatic testReset();
    check64("R12 reset result", {outHi, outLo}, 64'h0);
    checkBit("R12 reset valid", outValid, 1'b0);
    checkBit("R12 reset flag", satFlag, 1'b0);
  endtask

  task automatic testPlainLeft();
    clearFlag();
    run(3'd0, 64'h0000_0001_8000_0001, 32'h4, 64'h0000_0018_0000_0010, 0, "R3 left 4");
    run(3'd0, 64'h0000_0001_8000_0001, 32'hFFFF_FF04, 64'h0000_0018_0000_0010, 0, "R2 upper count bits ignored");
    run(3'd0, 64'h8000_0000_0000_0010, 32'hFC, 64'h0800_0000_0000_0001, 0, "R2 negative count logical right");
    run(3'd0, ONES, 32'h40, 64'h0, 0, "R3 left 64 gives zero");
    run(3'd0, ONES, 32'hC0, 64'h0, 0, "R3 right 64 gives zero");
  endtask

  task automatic testPlainArith();
    clearFlag();
    run(3'd1, 64'h8000_0000_0000_0000, 32'h4, 64'hF800_0000_0000_0000, 0, "R4 arithmetic right 4");
    run(3'd1, 64'h1, 32'hFC, 64'h10, 0, "R2 negated count goes left");
    run(3'd1, 64'h8000_0000_0000_0000, 32'h64, ONES, 0, "R4 right 100 sign fill");
    run(3'd1, 64'h1000_0000_0000_0000, 32'hFC, 64'h0, 0, "R4 overflow ignored");
    run(3'd1, 64'h5, 32'h9C, 64'h0, 0, "R4 left 100 gives zero");
  endtask

  task automatic testUnsigned64();
    clearFlag();
    run(3'd2, 64'h0FFF_FFFF_FFFF_FFFF, 32'h4, 64'hFFFF_FFFF_FFFF_FFF0, 0, "R6 left in range");
    run(3'd2, 64'd24, 32'hFC, 64'd2, 0, "R5 half rounds up");
    run(3'd2, 64'd23, 32'hFC, 64'd1, 0, "R5 below half rounds down");
    run(3'd2, 64'h8000_0000_0000_0000, 32'hC0, 64'd1, 0, "R6 right 64 keeps round bit");
    run(3'd2, ONES, 32'hBF, 64'h0, 0, "R6 right 65 gives zero");
    run(3'd2, 64'h0, 32'h40, 64'h0, 0, "R6 zero operand left 64");
    run(3'd2, 64'h1000_0000_0000_0000, 32'h4, ONES, 1, "R6 left overflow saturates");
  endtask

  task automatic testSigned64();
    clearFlag();
    run(3'd3, 64'hFFFF_FFFF_FFFF_FFE8, 32'h4, ONES, 0, "R5 signed half rounds up");
    run(3'd3, 64'h8000_0000_0000_0000, 32'h40, 64'h0, 0, "R7 right 64 gives zero");
    run(3'd3, 64'h0, 32'h80, 64'h0, 0, "R7 zero operand left 128");
    run(3'd3, 64'h4000_0000_0000_0000, 32'hFF, 64'h7FFF_FFFF_FFFF_FFFF, 1, "R7 positive saturation");
    clearFlag();
    run(3'd3, 64'h8000_0000_0000_0000, 32'hFF, 64'h8000_0000_0000_0000, 1, "R7 negative saturation");
  endtask

  task automatic testUnsigned48();
    clearFlag();
    run(3'd4, 64'h0000_0FFF_FFFF_FFFF, 32'h4, 64'h0000_FFFF_FFFF_FFF0, 0, "R8 left in range");
    run(3'd4, 64'h0000_8000_0000_0000, 32'hD0, 64'd1, 0, "R8 right 48 keeps round bit");
    run(3'd4, ONES, 32'hCF, 64'h0, 0, "R8 right 49 gives zero");
    run(3'd4, 64'h0, 32'h30, 64'h0, 0, "R8 zero operand left 48");
    run(3'd4, 64'h0000_1000_0000_0000, 32'h4, 64'h0000_FFFF_FFFF_FFFF, 1, "R8 left past 48 bits");
    clearFlag();
    run(3'd4, 64'h0100_0000_0000_0000, 32'hF8, 64'h0000_FFFF_FFFF_FFFF, 1, "R8 right result past 48 bits");
    clearFlag();
    run(3'd4, 64'h1, 32'h30, 64'h0000_FFFF_FFFF_FFFF, 1, "R8 nonzero left 48");
  endtask

  task automatic testSigned48();
    clearFlag();
    run(3'd5, 64'h0000_07FF_FFFF_FFFF, 32'hFC, 64'h0000_7FFF_FFFF_FFF0, 0, "R9 positive in range");
    run(3'd5, ONES, 32'hFC, 64'hFFFF_FFFF_FFFF_FFF0, 0, "R9 negative in range");
    run(3'd5, 64'h180, 32'h8, 64'd2, 0, "R9 rounded right");
    run(3'd5, 64'h7000_0000_0000_0000, 32'h4, 64'h0700_0000_0000_0000, 0, "R9 right keeps 64 bits");
    run(3'd5, 64'h8000_0000_0000_0000, 32'h30, 64'h0, 0, "R9 right 48 gives zero");
    run(3'd5, 64'h0000_0800_0000_0000, 32'hFC, 64'h0000_7FFF_FFFF_FFFF, 1, "R9 positive saturation");
    clearFlag();
    run(3'd5, 64'hFFFF_F000_0000_0000, 32'hFC, 64'hFFFF_8000_0000_0000, 1, "R9 negative saturation");
  endtask

  task automatic testFlag();
    clearFlag();
    run(3'd2, 64'h1000_0000_0000_0000, 32'h4, ONES, 1, "R10 flag set");
    run(3'd0, 64'h1, 32'h1, 64'h2, 1, "R10 flag survives plain op");
    repeat (3) @(negedge clk);
    checkBit("R10 flag held while idle", satFlag, 1'b1);
    clearFlag();
    checkBit("R10 flag cleared", satFlag, 1'b0);
    @(negedge clk);
    op = 3'd2; {hiWord, loWord} = 64'h1000_0000_0000_0000; countWord = 32'h4;
    inValid = 1'b1; satClear = 1'b1;
    @(negedge clk);
    inValid = 1'b0; satClear = 1'b0;
    checkBit("R10 set wins over clear", satFlag, 1'b1);
  endtask

  task automatic testKeep();
    clearFlag();
    run(3'd6, 64'h1234_5678_9ABC_DEF0, 32'h4, 64'h1234_5678_9ABC_DEF0, 0, "R11 code 6 copies");
    run(3'd7, 64'h8000_0000_0000_0001, 32'hFF, 64'h8000_0000_0000_0001, 0, "R11 code 7 copies");
  endtask

  task automatic testHold();
    @(negedge clk);
    op = 3'd0; {hiWord, loWord} = 64'h0000_0000_0000_00FF; countWord = 32'h8;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R1 valid pulse", outValid, 1'b1);
    check64("R1 result split", {outHi, outLo}, 64'h0000_0000_0000_FF00);
    {hiWord, loWord} = 64'hDEAD_BEEF_0BAD_F00D; countWord = 32'h1;
    @(negedge clk);
    checkBit("R1 valid drops", outValid, 1'b0);
    check64("R1 result held", {outHi, outLo}, 64'h0000_0000_0000_FF00);
  endtask

  task automatic finish();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testPlainLeft();
    testPlainArith();
    testUnsigned64();
    testSigned64();
    testUnsigned48();
    testSigned48();
    testFlag();
    testKeep();
    testHold();
    finish();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish();
  end

endmodule